// File: doc/BRIEF.md
# PLL Retuning Sequencer

This block steps one PLL safely from its current divider setting to a new one. A single start pulse carries the requested reference divider (NR), feedback multiplier (NF) and post-divider (NO). The sequencer first checks that request against the legal divider, VCO and output ranges. If the request is legal it moves the downstream clock consumer onto the slow reference path. It then holds the PLL in reset, writes the new divider and bandwidth fields, lets them settle for a fixed time, releases reset, and waits for lock. Only after lock does it return the consumer to the PLL output.

The divider fields are presented in the minus-one form that the PLL control words expect. The bandwidth field is derived from NF. A request that breaks any rule is refused on the spot and never disturbs the PLL. A lock that does not arrive within a bounded number of cycles ends the sequence with an error, and the consumer is left on the safe slow path.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, mode_o is 0 (slow), and pll_rst_o, done_o, err_o and every field output are 0.
- R2: A legal start taken in idle drives mode_o to 0 (slow) one cycle later. pll_rst_o rises on the following cycle, so the consumer is on the slow path before the PLL is disturbed.
- R3: The fields are written one cycle after pll_rst_o rises, as nr_field_o = NR-1, nf_field_o = NF-1, no_field_o = NO-1 and bw_field_o = (NF>>1)-1 taken to 12 bits. They change at no other time.
- R4: pll_rst_o stays high for exactly SETTLE_US*CYCLES_PER_US+1 cycles. With the defaults (2 cycles per microsecond, 10 microseconds) that is 21 cycles.
- R5: A request is refused when NR is outside 1..64, NF is outside 1..8192, NO is outside 1..16, or NO is odd and not 1.
- R6: A request is refused unless 440000*NR <= REF_KHZ*NF <= 2200000*NR (VCO between 440 and 2200 MHz) and 27500*NR*NO <= REF_KHZ*NF <= 2200000*NR*NO (output between 27.5 and 2200 MHz). REF_KHZ defaults to 24000.
- R7: A refused request sets err_o one cycle after the start. mode_o, pll_rst_o and the field outputs are left unchanged, and done_o stays low.
- R8: If lock_i is first seen high on the D-th cycle after pll_rst_o falls, with D <= LOCK_TIMEOUT, then mode_o becomes 1 (normal) and done_o pulses in that same cycle.
- R9: If lock has not been seen by the LOCK_TIMEOUT-th cycle after pll_rst_o falls, err_o rises in that cycle, mode_o stays 0 and done_o never pulses.
- R10: A start pulse while a sequence is running is ignored. The running sequence finishes with its own fields, and no error is raised.
- R11: done_o is high for exactly one cycle. err_o is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| nr_i | input | 7 | Requested reference divider NR |
| nf_i | input | 14 | Requested feedback multiplier NF |
| no_i | input | 5 | Requested post-divider NO |
| lock_i | input | 1 | PLL lock status |
| mode_o | output | 2 | Consumer source: 0 slow reference, 1 PLL output |
| pll_rst_o | output | 1 | PLL reset |
| nr_field_o | output | 6 | NR-1 |
| nf_field_o | output | 13 | NF-1 |
| no_field_o | output | 4 | NO-1 |
| bw_field_o | output | 12 | Bandwidth adjust (NF>>1)-1 |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Refused request or lock timeout |

## Verification
The post-divider is swept over all of 1..16 at a fixed legal VCO, which separates odd from even and 1 from the other odd values. NF is swept across both VCO edges, and a request sitting exactly on the lowest legal VCO at the largest divider shows whether the bounds are inclusive. Zero and over-range divider values check the field limits. Lock delays equal to the timeout and one beyond it separate a late success from a timeout, and a start pulse injected during settle checks that a running sequence cannot be disturbed.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_PROG,
    S_SETTLE,
    S_LOCK
  } seq_state_t;

  localparam logic [1:0] MODE_SLOW   = 2'd0;
  localparam logic [1:0] MODE_NORMAL = 2'd1;
endpackage

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int REF_KHZ     = 24000,
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int VCO_MIN_KHZ = 440000,
  parameter int VCO_MAX_KHZ = 2200000,
  parameter int OUT_MIN_KHZ = 27500,
  parameter int OUT_MAX_KHZ = 2200000
) (
  input  logic [NR_W:0] nr_i,
  input  logic [NF_W:0] nf_i,
  input  logic [NO_W:0] no_i,
  output logic          ok_o
);
  localparam int PW = 48;
  localparam logic [NR_W:0] NR_MAX = (NR_W+1)'(1 << NR_W);
  localparam logic [NF_W:0] NF_MAX = (NF_W+1)'(1 << NF_W);
  localparam logic [NO_W:0] NO_MAX = (NO_W+1)'(1 << NO_W);

  logic [PW-1:0] prod, nr_w, nrno_w;
  logic          fields_ok, no_ok, vco_ok, out_ok;

  always_comb begin
    prod   = PW'(REF_KHZ) * PW'(nf_i);
    nr_w   = PW'(nr_i);
    nrno_w = PW'(nr_i) * PW'(no_i);
    fields_ok = (nr_i != '0) && (nr_i <= NR_MAX) &&
                (nf_i != '0) && (nf_i <= NF_MAX) &&
                (no_i != '0) && (no_i <= NO_MAX);
    no_ok  = (no_i == (NO_W+1)'(1)) || !no_i[0];
    vco_ok = (prod >= PW'(VCO_MIN_KHZ) * nr_w) &&
             (prod <= PW'(VCO_MAX_KHZ) * nr_w);
    out_ok = (prod >= PW'(OUT_MIN_KHZ) * nrno_w) &&
             (prod <= PW'(OUT_MAX_KHZ) * nrno_w);
    ok_o   = fields_ok && no_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (dec_i && cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int REF_KHZ       = 24000,
  parameter int CYCLES_PER_US = 2,
  parameter int SETTLE_US     = 10,
  parameter int LOCK_TIMEOUT  = 64,
  parameter int NR_W          = 6,
  parameter int NF_W          = 13,
  parameter int NO_W          = 4,
  parameter int BW_W          = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NR_W:0]   nr_i,
  input  logic [NF_W:0]   nf_i,
  input  logic [NO_W:0]   no_i,
  input  logic            lock_i,
  output logic [1:0]      mode_o,
  output logic            pll_rst_o,
  output logic [NR_W-1:0] nr_field_o,
  output logic [NF_W-1:0] nf_field_o,
  output logic [NO_W-1:0] no_field_o,
  output logic [BW_W-1:0] bw_field_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int SETTLE_CYC = CYCLES_PER_US * SETTLE_US;
  localparam int CNT_MAX    = (SETTLE_CYC > LOCK_TIMEOUT) ? SETTLE_CYC : LOCK_TIMEOUT;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  seq_state_t state_q, state_d;
  logic [NR_W:0] nr_q;
  logic [NF_W:0] nf_q;
  logic [NO_W:0] no_q;
  logic          req_ok, t_zero, t_load, t_dec;
  logic [CNT_W-1:0] t_val;
  logic          acc, rej, rst_set, rst_clr, prog, fin_ok, fin_to;

  pll_req_check #(.REF_KHZ(REF_KHZ), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W)) u_check (
    .nr_i(nr_i), .nf_i(nf_i), .no_i(no_i), .ok_o(req_ok)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val),
    .dec_i(t_dec), .zero_o(t_zero)
  );

  always_comb begin
    state_d = state_q;
    acc = 1'b0; rej = 1'b0; rst_set = 1'b0; rst_clr = 1'b0; prog = 1'b0;
    fin_ok = 1'b0; fin_to = 1'b0;
    t_load = 1'b0; t_dec = 1'b0; t_val = '0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (req_ok) begin
            acc     = 1'b1;
            state_d = S_RST;
          end else begin
            rej = 1'b1;
          end
        end
      end
      S_RST: begin
        rst_set = 1'b1;
        state_d = S_PROG;
      end
      S_PROG: begin
        prog    = 1'b1;
        t_load  = 1'b1;
        t_val   = CNT_W'(SETTLE_CYC - 1);
        state_d = S_SETTLE;
      end
      S_SETTLE: begin
        if (t_zero) begin
          rst_clr = 1'b1;
          t_load  = 1'b1;
          t_val   = CNT_W'(LOCK_TIMEOUT - 1);
          state_d = S_LOCK;
        end else begin
          t_dec = 1'b1;
        end
      end
      S_LOCK: begin
        if (lock_i) begin
          fin_ok  = 1'b1;
          state_d = S_IDLE;
        end else if (t_zero) begin
          fin_to  = 1'b1;
          state_d = S_IDLE;
        end else begin
          t_dec = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      mode_o     <= MODE_SLOW;
      pll_rst_o  <= 1'b0;
      nr_q       <= '0;
      nf_q       <= '0;
      no_q       <= '0;
      nr_field_o <= '0;
      nf_field_o <= '0;
      no_field_o <= '0;
      bw_field_o <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin_ok;
      if (acc) begin
        nr_q <= nr_i;
        nf_q <= nf_i;
        no_q <= no_i;
      end
      if (acc)         mode_o <= MODE_SLOW;
      else if (fin_ok) mode_o <= MODE_NORMAL;
      if (rst_set)      pll_rst_o <= 1'b1;
      else if (rst_clr) pll_rst_o <= 1'b0;
      if (prog) begin
        nr_field_o <= NR_W'(nr_q - 1'b1);
        nf_field_o <= NF_W'(nf_q - 1'b1);
        no_field_o <= NO_W'(no_q - 1'b1);
        bw_field_o <= BW_W'((nf_q >> 1) - 1'b1);
      end
      if (rej || fin_to) err_o <= 1'b1;
      else if (acc)      err_o <= 1'b0;
    end
  end

  p_rst_while_slow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_o |-> (mode_o == MODE_SLOW));
  p_fields_under_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({nr_field_o, nf_field_o, no_field_o, bw_field_o}) |-> pll_rst_o);
  p_done_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mode_o == MODE_NORMAL && !pll_rst_o));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_err_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_rst_o && start_i) |=> !err_o);
endmodule

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_KHZ    = 24000;
  localparam int SETTLE_CYC = 20;
  localparam int TIMEOUT    = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  nr_i = '0;
  logic [13:0] nf_i = '0;
  logic [4:0]  no_i = '0;
  logic        lock_i = 1'b0;
  logic [1:0]  mode_o;
  logic        pll_rst_o;
  logic [5:0]  nr_field_o;
  logic [12:0] nf_field_o;
  logic [3:0]  no_field_o;
  logic [11:0] bw_field_o;
  logic        done_o, err_o;

  int n_chk = 0, n_bad = 0;
  int lock_delay = 3;
  int lk_cnt = 0;
  int exp_mode = 0;
  int exp_nr = 0, exp_nf = 0, exp_no = 0, exp_bw = 0;

  pll_retune_seq u_pll_retune_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nr_i(nr_i), .nf_i(nf_i),
    .no_i(no_i), .lock_i(lock_i), .mode_o(mode_o), .pll_rst_o(pll_rst_o),
    .nr_field_o(nr_field_o), .nf_field_o(nf_field_o), .no_field_o(no_field_o),
    .bw_field_o(bw_field_o), .done_o(done_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (pll_rst_o) lk_cnt = 0;
    else if (lk_cnt < 100000) lk_cnt = lk_cnt + 1;
    lock_i = !pll_rst_o && (lk_cnt >= lock_delay);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fields_chk(input string req);
    chk(req, nr_field_o, exp_nr);
    chk(req, nf_field_o, exp_nf);
    chk(req, no_field_o, exp_no);
    chk(req, bw_field_o, exp_bw);
  endtask

  function automatic bit legal(input int nr, input int nf, input int no);
    longint p;
    p = longint'(REF_KHZ) * nf;
    if (nr < 1 || nr > 64 || nf < 1 || nf > 8192 || no < 1 || no > 16) return 0;
    if (no != 1 && (no % 2) != 0) return 0;
    if (p < 440000 * longint'(nr) || p > 2200000 * longint'(nr)) return 0;
    if (p < 27500 * longint'(nr) * no || p > 2200000 * longint'(nr) * no) return 0;
    return 1;
  endfunction

  task automatic run_req(input int nr, input int nf, input int no, input int d,
                         input bit poke);
    bit ok;
    int rst_hi, wait_cnt, guard;
    bit fell, fin;
    ok = legal(nr, nf, no);
    lock_delay = d;
    nr_i = 7'(nr); nf_i = 14'(nf); no_i = 5'(no);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!ok) begin
      chk("R5/R6/R7 reject err", err_o, 1);
      chk("R7 reject mode", mode_o, exp_mode);
      chk("R7 reject pll_rst", pll_rst_o, 0);
      chk("R7 reject done", done_o, 0);
      fields_chk("R7 reject fields");
      @(negedge clk);
      chk("R7 reject stays idle", pll_rst_o, 0);
      return;
    end
    chk("R2 slow after start", mode_o, 0);
    chk("R2 rst not yet", pll_rst_o, 0);
    chk("R11 err cleared", err_o, 0);
    rst_hi = 0; wait_cnt = 0; fell = 0; fin = 0; guard = 0;
    while (!fin && guard < 400) begin
      @(negedge clk);
      guard++;
      start_i = 1'b0;
      if (pll_rst_o) begin
        rst_hi++;
        if (mode_o != 0) chk("R2 slow during reset", mode_o, 0);
        if (rst_hi == 1) begin
          chk("R3 fields unchanged at reset entry", nr_field_o, exp_nr);
        end
        if (poke && rst_hi == 5) begin
          nr_i = 7'd0; nf_i = 14'd3; no_i = 5'd3;
          start_i = 1'b1;
        end
      end else begin
        fell = 1;
        if (done_o || err_o) fin = 1;
        else wait_cnt++;
      end
    end
    exp_nr = nr - 1; exp_nf = nf - 1; exp_no = no - 1;
    exp_bw = ((nf >> 1) - 1) & 12'hfff;
    chk("R4 reset length", rst_hi, SETTLE_CYC + 1);
    fields_chk("R3 field values");
    if (d <= TIMEOUT) begin
      chk("R8 done", done_o, 1);
      chk("R8 lock latency", wait_cnt, d);
      chk("R8 mode normal", mode_o, 1);
      chk("R10 no err", err_o, 0);
      exp_mode = 1;
      @(negedge clk);
      chk("R11 done one cycle", done_o, 0);
    end else begin
      chk("R9 timeout err", err_o, 1);
      chk("R9 timeout latency", wait_cnt, TIMEOUT);
      chk("R9 mode stays slow", mode_o, 0);
      chk("R9 no done", done_o, 0);
      exp_mode = 0;
      @(negedge clk);
      chk("R9 no late done", done_o, 0);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", mode_o, 0);
    chk("R1 pll_rst", pll_rst_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0);
    fields_chk("R1 fields");
    rst_n = 1'b1;
    @(negedge clk);
    for (int no = 1; no <= 16; no++) run_req(1, 50, no, 3, 0);
    for (int nf = 16; nf <= 94; nf++) run_req(1, nf, 2, 1 + (nf % 5), 0);
    run_req(3, 55, 16, 2, 0);
    run_req(3, 54, 16, 2, 0);
    run_req(0, 50, 2, 2, 0);
    run_req(65, 50, 2, 2, 0);
    run_req(1, 0, 2, 2, 0);
    run_req(1, 50, 0, 2, 0);
    run_req(1, 50, 17, 2, 0);
    run_req(64, 8192, 16, 2, 0);
    run_req(64, 8193, 16, 2, 0);
    run_req(2, 100, 4, TIMEOUT, 0);
    run_req(2, 100, 4, TIMEOUT + 1, 0);
    run_req(2, 150, 6, 1, 0);
    run_req(4, 300, 8, 5, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule